// File: doc/BRIEF.md
# Fixed-Length Codeword Binary Arithmetic Coder

This block turns a stream of binary symbols into a sequence of independent 16-bit codewords. Each symbol arrives with a 16-bit fixed-point estimate of the chance that it is zero. The coder keeps an interval as a lower bound and a size. Each symbol narrows that interval: a zero keeps the lower part of the range, and a one keeps the upper part. When the size reaches zero the codeword is complete, and its lower bound is written out as one codeword. There is no carry propagation and no renormalisation, so every codeword can be decoded without reference to any other codeword.

A codeword needs a place in the bitstream before its first symbol is coded. When a symbol arrives and no codeword is open, the coder raises a slot request and holds the symbol. An external allocator grants the request and supplies an address. That address then goes out with the finished codeword. At the end of a block of coefficients, a flush pulse forces out a codeword that is only partly used.

Top module: `fcw_arith_coder`

## Requirements
- R1: While reset is held and in the cycle after it, sym_ready and cw_valid are 0. slot_req is 0 while sym_valid is 0.
- R2: When no codeword is open, sym_ready is 0 and slot_req equals sym_valid, so the symbol stalls. In a cycle with slot_req and slot_grant both high, the coder captures slot_addr, sets the lower bound to 0 and the size to 0xFFFF, and raises sym_ready in the next cycle. That granting cycle consumes no symbol.
- R3: An accepted zero symbol (sym_bit 0) leaves the lower bound unchanged and sets the size to (size * sym_prob) >> 16. sym_prob is an unsigned fraction of 2^16.
- R4: An accepted one symbol computes t = ((size * sym_prob) >> 16) + 1. It adds t to the lower bound and subtracts t from the size.
- R5: When an accepted symbol brings the size to 0, cw_valid is 1 for exactly the next cycle. In that cycle cw_data holds the resulting lower bound and cw_addr holds the slot address granted for that codeword. The next symbol then requests a new slot.
- R6: A flush pulse while a codeword is open, in a cycle where no symbol is accepted, writes out the current lower bound and granted address in the next cycle and closes the codeword. If a symbol is accepted in the same cycle, the symbol is coded and the flush has no effect.
- R7: A flush pulse while no codeword is open has no effect: cw_valid stays 0 in the next cycle.
- R8: The lower bound plus the size never exceeds 0xFFFF. At most one symbol is accepted per cycle.
- R9: cw_valid is 1 only in the cycle after a codeword is exhausted or flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_bit | input | 1 | Symbol value |
| sym_prob | input | 16 | Probability of a zero, as a fraction of 2^16 |
| sym_ready | output | 1 | The symbol is accepted this cycle if it is valid |
| flush | input | 1 | Force out the open codeword |
| slot_req | output | 1 | Request for a new bitstream slot |
| slot_grant | input | 1 | The allocator grants the request |
| slot_addr | input | ADDR_W | Address of the granted slot |
| cw_valid | output | 1 | Codeword write strobe |
| cw_addr | output | ADDR_W | Slot address for the codeword |
| cw_data | output | 16 | Codeword value |

## Verification
The lower bound and the size are hidden. A wrong interval update shows up only in the next codeword write, either as a wrong cw_data value or as a write that comes too early or too late. That can be many symbols after the faulty step, so the bench runs a cycle-accurate model and compares every cycle's cw_valid, cw_data and cw_addr. Flushes placed at random points expose the lower bound partway through a codeword. A wrong open/closed state shows up at once, as a mismatch in sym_ready or slot_req in the same cycle.

// File: rtl/fcw_pkg.sv
`timescale 1ns/1ps
package fcw_pkg;
    localparam int CW_W   = 16;
    localparam int PROB_W = 16;
    localparam int PROD_W = CW_W + PROB_W;

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [PROB_W-1:0] prob_t;

    typedef struct packed {
        cw_t low;
        cw_t size;
    } interval_t;

    localparam cw_t CW_FULL = {CW_W{1'b1}};

    // Scaled portion of the interval that belongs to a zero symbol
    function automatic cw_t zero_part(cw_t size, prob_t p);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(size) * PROD_W'(p);
        return prod[PROD_W-1:PROB_W];
    endfunction
endpackage

// File: rtl/fcw_interval.sv
`timescale 1ns/1ps
module fcw_interval
    import fcw_pkg::*;
(
    input  interval_t iv_q,
    input  logic      sym_bit,
    input  prob_t     sym_prob,
    output interval_t iv_next,
    output logic      exhaust
);
    cw_t part;
    cw_t step;

    always_comb begin
        part = zero_part(iv_q.size, sym_prob);
        step = part + cw_t'(1);
        if (sym_bit) begin
            iv_next.low  = iv_q.low + step;
            iv_next.size = iv_q.size - step;
        end else begin
            iv_next.low  = iv_q.low;
            iv_next.size = part;
        end
        exhaust = (iv_next.size == '0);
    end
endmodule

// File: rtl/fcw_slot_ctrl.sv
`timescale 1ns/1ps
module fcw_slot_ctrl #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              need_slot,
    input  logic              slot_grant,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              slot_req,
    output logic              slot_taken,
    output logic [ADDR_W-1:0] addr_q
);
    assign slot_req   = need_slot;
    assign slot_taken = need_slot & slot_grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (slot_taken) begin
            addr_q <= slot_addr;
        end
    end
endmodule

// File: rtl/fcw_emit.sv
`timescale 1ns/1ps
module fcw_emit
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  cw_t               data,
    output logic              cw_valid,
    output logic [ADDR_W-1:0] cw_addr,
    output cw_t               cw_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cw_valid <= 1'b0;
            cw_addr  <= '0;
            cw_data  <= '0;
        end else begin
            cw_valid <= fire;
            if (fire) begin
                cw_addr <= addr;
                cw_data <= data;
            end
        end
    end
endmodule

// File: rtl/fcw_arith_coder.sv
`timescale 1ns/1ps
module fcw_arith_coder
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  logic              sym_bit,
    input  logic [PROB_W-1:0] sym_prob,
    output logic              sym_ready,
    input  logic              flush,
    output logic              slot_req,
    input  logic              slot_grant,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              cw_valid,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [CW_W-1:0]   cw_data
);
    interval_t         iv_q;
    interval_t         iv_nx;
    logic              exhaust;
    logic              cw_open;
    logic              accept;
    logic              slot_taken;
    logic              flush_fire;
    logic              fire;
    cw_t               out_data;
    logic [ADDR_W-1:0] addr_q;

    assign cw_open    = (iv_q.size != '0);
    assign sym_ready  = cw_open;
    assign accept     = sym_valid & cw_open;
    assign flush_fire = flush & cw_open & ~accept;

    fcw_slot_ctrl #(.ADDR_W(ADDR_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .need_slot  (sym_valid & ~cw_open),
        .slot_grant (slot_grant),
        .slot_addr  (slot_addr),
        .slot_req   (slot_req),
        .slot_taken (slot_taken),
        .addr_q     (addr_q)
    );

    fcw_interval u_iv (
        .iv_q     (iv_q),
        .sym_bit  (sym_bit),
        .sym_prob (sym_prob),
        .iv_next  (iv_nx),
        .exhaust  (exhaust)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q <= '0;
        end else if (accept) begin
            iv_q <= iv_nx;
        end else if (slot_taken) begin
            iv_q.low  <= '0;
            iv_q.size <= CW_FULL;
        end else if (flush_fire) begin
            iv_q.size <= '0;
        end
    end

    assign fire     = (accept & exhaust) | flush_fire;
    assign out_data = accept ? iv_nx.low : iv_q.low;

    fcw_emit #(.ADDR_W(ADDR_W)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .addr     (addr_q),
        .data     (out_data),
        .cw_valid (cw_valid),
        .cw_addr  (cw_addr),
        .cw_data  (cw_data)
    );
endmodule

// File: rtl/fcw_arith_coder_chk.sv
`timescale 1ns/1ps
module fcw_arith_coder_chk (
    input logic        clk,
    input logic        rst,
    input logic        sym_valid,
    input logic        sym_bit,
    input logic        sym_ready,
    input logic        slot_req,
    input logic        slot_grant,
    input logic        cw_valid,
    input logic [15:0] iv_low,
    input logic [15:0] iv_size
);
    logic [16:0] span;
    assign span = {1'b0, iv_low} + {1'b0, iv_size};

    assert_bound_R8: assert property (@(posedge clk) disable iff (rst)
        span <= 17'h0FFFF);

    assert_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !sym_ready) |-> slot_req);

    assert_open_full_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_req && slot_grant) |=> (sym_ready && iv_low == 16'h0000 && iv_size == 16'hFFFF));

    assert_req_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(slot_req && sym_ready));

    assert_zero_keeps_low_R3: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && !sym_bit) |=> (iv_low == $past(iv_low) && iv_size < $past(iv_size)));

    assert_one_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_bit) |=> (span == $past(span) && iv_low > $past(iv_low)));

    assert_closed_after_cw_R5: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> !sym_ready);
endmodule

bind fcw_arith_coder fcw_arith_coder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym_bit    (sym_bit),
    .sym_ready  (sym_ready),
    .slot_req   (slot_req),
    .slot_grant (slot_grant),
    .cw_valid   (cw_valid),
    .iv_low     (iv_q.low),
    .iv_size    (iv_q.size)
);

// File: tb/fcw_arith_coder_tb.sv
`timescale 1ns/1ps
module fcw_arith_coder_tb_top;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sym_valid = 1'b0;
    logic              sym_bit = 1'b0;
    logic [15:0]       sym_prob = '0;
    logic              sym_ready;
    logic              flush = 1'b0;
    logic              slot_req;
    logic              slot_grant = 1'b0;
    logic [ADDR_W-1:0] slot_addr = '0;
    logic              cw_valid;
    logic [ADDR_W-1:0] cw_addr;
    logic [15:0]       cw_data;

    always #4 clk = ~clk;

    fcw_arith_coder #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
        .sym_prob(sym_prob), .sym_ready(sym_ready), .flush(flush),
        .slot_req(slot_req), .slot_grant(slot_grant), .slot_addr(slot_addr),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of the coder state
    logic [15:0]       mz = '0;
    logic [15:0]       ml = '0;
    logic [ADDR_W-1:0] maddr = '0;
    logic [ADDR_W-1:0] next_addr = 12'h100;
    logic [15:0]       last_data;
    logic              last_valid;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] part_of(input logic [15:0] z, input logic [15:0] p);
        logic [31:0] prod;
        prod = {16'h0, z} * {16'h0, p};
        return prod[31:16];
    endfunction

    // Called at a falling edge: drive, predict, advance one cycle, compare
    task automatic step(input logic v, input logic b, input logic [15:0] p, input logic g, input logic f);
        logic        nv;
        logic [15:0] nd;
        logic [ADDR_W-1:0] na;
        logic [15:0] t;
        string       tag;
        sym_valid = v; sym_bit = b; sym_prob = p; slot_grant = g; flush = f;
        slot_addr = next_addr;
        #1;
        check(sym_ready == (mz != 0), "R2 ready", 32'(sym_ready), 32'(mz != 0));
        check(slot_req == (v && mz == 0), "R2 request", 32'(slot_req), 32'(v && mz == 0));
        nv = 0; nd = '0; na = '0; tag = "R9";
        if (v && mz != 0) begin
            t = part_of(mz, p);
            if (b) begin
                t = t + 16'd1;
                ml = ml + t;
                mz = mz - t;
            end else begin
                mz = t;
            end
            if (mz == 0) begin
                nv = 1; nd = ml; na = maddr; tag = "R5";
            end
        end else if (v && mz == 0 && g) begin
            mz = 16'hFFFF; ml = '0; maddr = next_addr;
            next_addr = next_addr + 1'b1;
        end else if (f && mz != 0) begin
            nv = 1; nd = ml; na = maddr; mz = '0; tag = "R6";
        end else if (f) begin
            tag = "R7";
        end
        @(negedge clk);
        last_valid = cw_valid;
        last_data  = cw_data;
        check(cw_valid == nv, tag, 32'(cw_valid), 32'(nv));
        if (nv) begin
            check(cw_data == nd, tag, 32'(cw_data), 32'(nd));
            check(cw_addr == na, tag, 32'(cw_addr), 32'(na));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cycles = 0;
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check(sym_ready == 0, "R1 ready in reset", 32'(sym_ready), 0);
        check(cw_valid == 0, "R1 valid in reset", 32'(cw_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sym_ready == 0, "R1 ready after reset", 32'(sym_ready), 0);
        check(slot_req == 0, "R1 request after reset", 32'(slot_req), 0);
        check(cw_valid == 0, "R1 valid after reset", 32'(cw_valid), 0);

        // R2: stall without grant, then open
        step(1, 0, 16'h0000, 0, 0);
        step(1, 0, 16'h0000, 0, 0);
        step(1, 0, 16'h0000, 1, 0);
        // R3: zero bit with P=0 exhausts at once with low 0
        step(1, 0, 16'h0000, 0, 0);
        check(last_valid && last_data == 16'h0000, "R3 zero bit P=0", 32'(last_data), 0);

        // R7: flush with nothing open
        step(0, 0, 16'h0000, 0, 1);
        check(!last_valid, "R7 idle flush", 32'(last_valid), 0);

        // R4 then R6: two one bits then flush
        step(1, 1, 16'h0000, 1, 0);
        step(1, 1, 16'h0000, 0, 0);
        step(1, 1, 16'h8000, 0, 0);
        step(0, 0, 16'h0000, 0, 1);
        check(last_valid && last_data == 16'h8001, "R4 R6 flushed low", 32'(last_data), 32'h8001);
        step(0, 0, 16'h0000, 0, 1);
        check(!last_valid, "R7 second flush", 32'(last_valid), 0);

        // R3 and R5: one bit then zero bit with P=0
        step(1, 0, 16'h0000, 1, 0);
        step(1, 1, 16'h0000, 0, 0);
        step(1, 0, 16'h0000, 0, 0);
        check(last_valid && last_data == 16'h0001, "R5 exhaust low", 32'(last_data), 1);

        // R6: flush together with an accepted symbol is ignored
        step(1, 0, 16'h0000, 1, 0);
        step(1, 0, 16'hFFFF, 0, 1);
        check(!last_valid, "R6 flush with symbol", 32'(last_valid), 0);
        step(0, 0, 16'h0000, 0, 1);
        check(last_valid && last_data == 16'h0000, "R6 flush after P max", 32'(last_data), 0);

        // Random traffic (R3 R4 R5 R6 R8 R9)
        for (int i = 0; i < 6000; i++) begin
            logic        v, b, g, f;
            logic [15:0] p;
            v = ($urandom % 4) != 0;
            b = $urandom % 2;
            case ($urandom % 5)
                0: p = 16'h0000;
                1: p = 16'hFFFF;
                default: p = 16'($urandom);
            endcase
            g = ($urandom % 3) == 0;
            f = ($urandom % 40) == 0;
            step(v, b, p, g, f);
        end
        step(0, 0, 16'h0000, 0, 1);
        finish_run();
    end
endmodule